// File: doc/BRIEF.md
# Remote Update Control Register Block

This block is a small memory-mapped slave that lets any bus master prepare and launch a change from the factory configuration image to an application image, with no processor involved. Through a single-cycle, read-latency-one slave port the master loads a watchdog timeout and a 32-bit boot start address, checks both through separate read-back offsets, and finally writes a trigger word. The block then emits a one-cycle reconfiguration request carrying the stored boot address, and from then on it accepts no more bus writes until reset.

It also runs a watchdog. Once armed, a down-counter starts at the timeout value multiplied by a fixed prescaler and counts one step per clock. It can be reloaded by a refresh write. If it reaches zero while armed, a sticky expiry flag is set.

Top module: `rupd_ctrl`

## Requirements
- R1: After reset, the stored timeout is 0, the boot address is 0, the watchdog is disarmed, the expiry flag is 0 and the reconfiguration request is 0.
- R2: A write to byte offset 0x20 stores the low 12 bits of the write data as the timeout. A read of offset 0x2C returns that value zero-extended to 32 bits.
- R3: A write to byte offset 0x40 stores all 32 bits as the boot address. A read of offset 0x4C returns it.
- R4: waitrequest stays low at all times. Read data for a read asserted in cycle n appears on readdata in cycle n+1.
- R5: Reads of any offset other than 0x2C and 0x4C return zero, including the write offsets 0x20 and 0x40. Writes to 0x2C, 0x4C or any unmapped offset change no stored value.
- R6: A write of exactly 0x1 to byte offset 0x74 raises the reconfiguration request for exactly one cycle, starting the cycle after the write, with the boot address output equal to the stored boot address. A write of any other value to 0x74 does nothing.
- R7: After the request has fired, every bus write is ignored until reset: stored values keep their contents and no second request occurs. Reads still work.
- R8: A write of 0x1 to byte offset 0x30 arms the watchdog and loads the counter with timeout × PRESCALE. The expiry flag rises timeout × PRESCALE + 1 cycles after the arming write's clock edge.
- R9: A write of 0x0 to byte offset 0x30 disarms the watchdog, which freezes the counter, so no expiry occurs.
- R10: A write of 0x1 to byte offset 0x34 reloads the counter with timeout × PRESCALE. A refresh in the same cycle in which an armed counter sits at zero wins, and the flag stays low.
- R11: The expiry flag is sticky. Once set, it stays set until reset, even if the watchdog is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| avs_address | input | ADDR_W | Byte offset of the access |
| avs_read | input | 1 | Read strobe |
| avs_write | input | 1 | Write strobe |
| avs_writedata | input | 32 | Write data |
| avs_readdata | output | 32 | Read data, valid one cycle after the read |
| avs_waitrequest | output | 1 | Always low |
| reconf_req | output | 1 | One-cycle reconfiguration request |
| reconf_addr | output | 32 | Boot address that accompanies the request |
| wd_expired | output | 1 | Sticky watchdog expiry flag |

## Verification
The watchdog reaching zero and a refresh write can land in the same clock cycle. In that cycle the flag would set and the counter would reload at once. The bench arms the watchdog with a known timeout and counts exactly timeout × PRESCALE cycles, so that the refresh write is captured on the edge where the counter is zero. It then requires the flag to stay low and expiry to occur only after a full new period. A second overlap is also checked: the trigger write locks the block, so a later refresh or boot-address write must leave both the readback values and the request line untouched.

// File: rtl/rupd_ctrl.sv
module rupd_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int TMO_W    = 12,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] avs_address,
  input  logic              avs_read,
  input  logic              avs_write,
  input  logic [31:0]       avs_writedata,
  output logic [31:0]       avs_readdata,
  output logic              avs_waitrequest,
  output logic              reconf_req,
  output logic [31:0]       reconf_addr,
  output logic              wd_expired
);

  localparam int CNT_W = TMO_W + $clog2(PRESCALE + 1);
  localparam logic [ADDR_W-1:0] OFS_TMO_WR  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] OFS_TMO_RD  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] OFS_WD_EN   = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFS_WD_KICK = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] OFS_BOOT_WR = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] OFS_BOOT_RD = ADDR_W'(8'h4C);
  localparam logic [ADDR_W-1:0] OFS_GO      = ADDR_W'(8'h74);

  logic [TMO_W-1:0] tmo_q;
  logic [31:0]      boot_q;
  logic             wd_en;
  logic             locked;
  logic [CNT_W-1:0] wd_cnt;

  wire             wr_ok   = avs_write && !locked;
  wire             wd_one  = (avs_writedata == 32'd1);
  wire             wd_zero = (avs_writedata == 32'd0);
  wire             arm     = wr_ok && (avs_address == OFS_WD_EN) && wd_one;
  wire             kick    = wr_ok && (avs_address == OFS_WD_KICK) && wd_one;
  wire [CNT_W-1:0] load    = CNT_W'(tmo_q) * CNT_W'(PRESCALE);

  assign avs_waitrequest = 1'b0;
  assign reconf_addr     = boot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q      <= '0;
      boot_q     <= '0;
      wd_en      <= 1'b0;
      locked     <= 1'b0;
      reconf_req <= 1'b0;
    end else begin
      reconf_req <= 1'b0;
      if (wr_ok) begin
        case (avs_address)
          OFS_TMO_WR:  tmo_q  <= avs_writedata[TMO_W-1:0];
          OFS_BOOT_WR: boot_q <= avs_writedata;
          OFS_WD_EN: begin
            if (wd_one)       wd_en <= 1'b1;
            else if (wd_zero) wd_en <= 1'b0;
          end
          OFS_GO: begin
            if (wd_one) begin
              reconf_req <= 1'b1;
              locked     <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt     <= '0;
      wd_expired <= 1'b0;
    end else begin
      if (arm || kick)
        wd_cnt <= load;
      else if (wd_en && wd_cnt != '0)
        wd_cnt <= wd_cnt - 1'b1;
      if (wd_en && wd_cnt == '0 && !arm && !kick)
        wd_expired <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avs_readdata <= '0;
    end else begin
      avs_readdata <= '0;
      if (avs_read) begin
        case (avs_address)
          OFS_TMO_RD:  avs_readdata <= 32'(tmo_q);
          OFS_BOOT_RD: avs_readdata <= boot_q;
          default:     avs_readdata <= '0;
        endcase
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req |=> !reconf_req);

  a_r6_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req |-> $stable(reconf_addr));

  a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(boot_q) && $stable(tmo_q) && !reconf_req));

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && !arm && !kick) |=> $stable(wd_cnt));

  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (wd_cnt == CNT_W'($past(tmo_q)) * CNT_W'(PRESCALE)));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |=> wd_expired);

endmodule

// File: tb/test_rupd_ctrl.sv
module test_rupd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  avs_address = '0;
  logic        avs_read = 1'b0;
  logic        avs_write = 1'b0;
  logic [31:0] avs_writedata = '0;
  logic [31:0] avs_readdata;
  logic        avs_waitrequest;
  logic        reconf_req;
  logic [31:0] reconf_addr;
  logic        wd_expired;

  int errors = 0;
  int checks = 0;
  localparam int PS = 4;

  always #2.5 clk = ~clk;

  rupd_ctrl #(.ADDR_W(8), .TMO_W(12), .PRESCALE(PS)) i_rupd_ctrl (
    .clk(clk), .rst_n(rst_n), .avs_address(avs_address), .avs_read(avs_read),
    .avs_write(avs_write), .avs_writedata(avs_writedata), .avs_readdata(avs_readdata),
    .avs_waitrequest(avs_waitrequest), .reconf_req(reconf_req),
    .reconf_addr(reconf_addr), .wd_expired(wd_expired)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    avs_address = a; avs_writedata = d; avs_write = 1'b1;
    @(negedge clk);
    avs_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    avs_address = a; avs_read = 1'b1;
    @(negedge clk);
    avs_read = 1'b0;
    d = avs_readdata;
    chk(avs_waitrequest == 1'b0, "R4 waitrequest low", 32'(avs_waitrequest), 0);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    chk(reconf_req == 1'b0, "R1 request idle", 32'(reconf_req), 0);
    chk(wd_expired == 1'b0, "R1 flag clear", 32'(wd_expired), 0);
    rd(8'h2C, d); chk(d == 0, "R1 timeout zero", d, 0);
    rd(8'h4C, d); chk(d == 0, "R1 boot zero", d, 0);
    repeat (10) @(negedge clk);
    chk(wd_expired == 1'b0, "R1 watchdog disarmed", 32'(wd_expired), 0);
  endtask

  task automatic t_registers();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FABC);
    rd(8'h2C, d); chk(d == 32'h0000_0ABC, "R2 timeout readback", d, 32'hABC);
    wr(8'h40, 32'h0040_0000);
    rd(8'h4C, d); chk(d == 32'h0040_0000, "R3 boot readback", d, 32'h0040_0000);
    wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h4C, d); chk(d == 32'hDEAD_BEEF, "R3 boot all bits", d, 32'hDEAD_BEEF);
    avs_address = 8'h4C; avs_read = 1'b1;
    @(posedge clk); #1;
    chk(avs_readdata == 32'hDEAD_BEEF, "R4 data one cycle later", avs_readdata, 32'hDEAD_BEEF);
    @(negedge clk); avs_read = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(8'h20, d); chk(d == 0, "R5 read of write offset 0x20", d, 0);
    rd(8'h40, d); chk(d == 0, "R5 read of write offset 0x40", d, 0);
    rd(8'h10, d); chk(d == 0, "R5 unmapped read", d, 0);
    wr(8'h2C, 32'h123); wr(8'h4C, 32'h5555_5555); wr(8'h24, 32'h77); wr(8'h44, 32'h9999);
    rd(8'h2C, d); chk(d == 32'hABC, "R5 timeout untouched", d, 32'hABC);
    rd(8'h4C, d); chk(d == 32'hDEAD_BEEF, "R5 boot untouched", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_expire();
    wr(8'h20, 32'd3);
    wr(8'h30, 32'd1);
    repeat (3 * PS) @(negedge clk);
    chk(wd_expired == 1'b0, "R8 no expiry before period", 32'(wd_expired), 0);
    @(negedge clk);
    chk(wd_expired == 1'b1, "R8 expiry on time", 32'(wd_expired), 1);
    wr(8'h30, 32'd0);
    repeat (5) @(negedge clk);
    chk(wd_expired == 1'b1, "R11 flag sticky after disarm", 32'(wd_expired), 1);
  endtask

  task automatic t_refresh_race();
    wr(8'h20, 32'd3);
    wr(8'h30, 32'd1);
    repeat (3 * PS) @(negedge clk);
    wr(8'h34, 32'd1);
    chk(wd_expired == 1'b0, "R10 refresh wins at zero", 32'(wd_expired), 0);
    repeat (3 * PS) @(negedge clk);
    chk(wd_expired == 1'b0, "R10 full period after refresh", 32'(wd_expired), 0);
    @(negedge clk);
    chk(wd_expired == 1'b1, "R10 expiry after refreshed period", 32'(wd_expired), 1);
  endtask

  task automatic t_disarm();
    wr(8'h20, 32'd2);
    wr(8'h30, 32'd1);
    repeat (3) @(negedge clk);
    wr(8'h30, 32'd0);
    repeat (40) @(negedge clk);
    chk(wd_expired == 1'b0, "R9 disarmed never expires", 32'(wd_expired), 0);
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    wr(8'h40, 32'h0040_0000);
    wr(8'h74, 32'd2);
    chk(reconf_req == 1'b0, "R6 other value ignored", 32'(reconf_req), 0);
    wr(8'h74, 32'd1);
    chk(reconf_req == 1'b1, "R6 request raised", 32'(reconf_req), 1);
    chk(reconf_addr == 32'h0040_0000, "R6 boot address carried", reconf_addr, 32'h0040_0000);
    @(negedge clk);
    chk(reconf_req == 1'b0, "R6 single cycle", 32'(reconf_req), 0);
    wr(8'h40, 32'h1111_2222);
    wr(8'h20, 32'd7);
    rd(8'h4C, d); chk(d == 32'h0040_0000, "R7 boot locked", d, 32'h0040_0000);
    rd(8'h2C, d); chk(d == 32'd2, "R7 timeout locked", d, 2);
    wr(8'h74, 32'd1);
    chk(reconf_req == 1'b0, "R7 no second request", 32'(reconf_req), 0);
    wr(8'h30, 32'd1);
    repeat (2 * PS + 4) @(negedge clk);
    chk(wd_expired == 1'b0, "R7 arming ignored after lock", 32'(wd_expired), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_registers();
    t_unmapped();
    t_expire();
    do_reset();
    t_refresh_race();
    do_reset();
    t_disarm();
    t_trigger();
    do_reset();
    chk(wd_expired == 1'b0, "R11 cleared only by reset", 32'(wd_expired), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule